// File: doc/BRIEF.md
# Blanking-Synchronized Video Control Register Bank

This block holds the alignment and control settings of a three-channel video preamplifier. These are brightness, contrast, on-screen-display contrast, a gain and a reference level for each channel, black level, pedestal depth, and a small control field. Software writes the settings through a two-wire serial slave front-end, which sits outside this block. That front-end reports start, stop, address-match and received-byte events as one-cycle strobes. For every received byte, the block returns an acknowledge decision in the same cycle as the strobe.

The first data byte of a transfer is a subaddress. If its top bit is clear, the transfer is direct. Data bytes fill a shadow copy, with the subaddress advancing after each byte, and the whole transfer becomes visible at its end. If the top bit is set, the transfer is buffered. Exactly one data byte is parked in a holding buffer and applied on the next rising edge of vertical blanking. This lets picture-visible adjustments change only while the beam is blanked.

After reset, and after a supply dip, all settings return to their defaults and a power-on flag is raised. While that flag is raised, the subaddress byte of a transfer is refused. The flag is lowered only by addressing the control register. A read port exposes the live values.

Top module: `blankSyncRegBank`

## Requirements
- R1: After reset, register 0 (control field, bits [3:0], bit 0 = output polarity) reads 0x01 and registers 1 to 11 read 0x00.
- R2: A subaddress byte with bit 7 = 0 starts a direct transfer. Its bytes are acknowledged, and the live registers stay unchanged until the stop (or repeated start) that ends the transfer, when all of them take the written values.
- R3: In a direct transfer, each data byte after the first goes to the next subaddress. The address stops advancing at 11, so later bytes rewrite register 11. A subaddress of 12 or above is acknowledged, but its data changes no register.
- R4: Stored field widths: register 0 keeps bits [3:0], register 3 (OSD contrast) keeps [3:0], register 10 (black level) keeps [2:0] and register 11 (pedestal depth) keeps [1:0]. The other registers keep all 8 bits. Discarded bits read 0.
- R5: A subaddress byte with bit 7 = 1 starts a buffered transfer. Its first data byte is held and applied to register (bit 6..0 of the subaddress) on the first rising edge of the synchronized blanking input after the transfer has ended. A blanking level held high without a new rising edge applies nothing.
- R6: Once a buffered write is held (ended and not yet applied), a new buffered subaddress is not acknowledged and its data is dropped. In a buffered transfer, every byte after the first data byte is not acknowledged and is ignored.
- R7: Direct transfers are accepted and applied while a buffered write is held, without waiting for blanking.
- R8: While the power-on flag is set, the subaddress byte and all later bytes of that transfer are not acknowledged and write nothing. The flag clears only when that refused subaddress has bits 6..0 equal to 0.
- R9: A powerDip pulse returns every register to its R1 value, discards any held buffered write and sets the power-on flag.
- R10: Reading a register index of 12 or above returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-up) |
| powerDip | input | 1 | One-cycle pulse reporting a supply dip |
| startStb | input | 1 | Start or repeated-start condition seen |
| stopStb | input | 1 | Stop condition seen |
| addrMatch | input | 1 | Device address matched for a write |
| byteStb | input | 1 | A data byte has been received |
| byteData | input | 8 | Received byte, valid with byteStb |
| ackOut | output | 1 | Acknowledge decision for the byte, valid with byteStb |
| vblankIn | input | 1 | Asynchronous vertical blanking level |
| rdAddr | input | 4 | Register index for the read port |
| rdData | output | 8 | Live value of the indexed register |

## Verification
The bench builds the block with its default two-stage blanking synchronizer. That default fixes the commit to the third clock edge after blanking rises, so the bench can sample a buffered register both before and after the commit. With the fixed twelve-entry map, the auto-increment limit, the out-of-range subaddresses and the narrow fields all stay reachable. These are exercised by sequences of direct and buffered transfers that are interleaved with blanking edges, held blanking levels and supply dips.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 12;
  localparam int SUB_W    = 7;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // Bits kept by each register; narrow fields drop their upper bits
  function automatic logic [DATA_W-1:0] fieldMask(input int idx);
    case (idx)
      0, 3:    fieldMask = 8'h0F;
      10:      fieldMask = 8'h07;
      11:      fieldMask = 8'h03;
      default: fieldMask = 8'hFF;
    endcase
  endfunction

  // Power-up value: only the polarity bit of the control field is set
  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    resetVal = (idx == 0) ? 8'h01 : 8'h00;
  endfunction

  typedef enum logic [2:0] {
    XF_IDLE, XF_WAIT_SUB, XF_DIRECT, XF_BUF_DATA, XF_BUF_DONE, XF_IGNORE
  } xferState_t;

  typedef struct packed {
    logic              shadowWr;
    logic [SUB_W-1:0]  wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              publish;
    logic              holdWr;
    logic              commit;
    logic              wipe;
  } ctrlStb_t;
endpackage

// File: rtl/vrbCtrl.sv
module vrbCtrl
  import vrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDip,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              addrMatch,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              vblankIn,
  output logic              ackOut,
  output ctrlStb_t          stb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   blankPrevQ;
  logic                   blankRise;
  xferState_t             stateQ, stateN;
  logic [SUB_W-1:0]       ptrQ, ptrN;
  logic                   porQ, porN;
  logic                   pendQ, pendN;
  logic                   endXfer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ      <= '0;
      blankPrevQ <= 1'b0;
    end else begin
      syncQ      <= {syncQ[SYNC_STAGES-2:0], vblankIn};
      blankPrevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign blankRise = syncQ[SYNC_STAGES-1] & ~blankPrevQ;
  assign endXfer   = startStb | stopStb;

  always_comb begin
    stateN     = stateQ;
    ptrN       = ptrQ;
    porN       = porQ;
    pendN      = pendQ;
    ackOut     = 1'b0;
    stb        = '0;
    stb.wrAddr = ptrQ;
    stb.wrData = byteData;

    if (blankRise && pendQ) begin
      stb.commit = 1'b1;
      pendN      = 1'b0;
    end

    if (endXfer) begin
      if (stateQ == XF_DIRECT)   stb.publish = 1'b1;
      if (stateQ == XF_BUF_DONE) pendN = 1'b1;
      stateN = XF_IDLE;
    end else if (addrMatch) begin
      stateN = XF_WAIT_SUB;
    end else if (byteStb) begin
      case (stateQ)
        XF_WAIT_SUB: begin
          if (porQ) begin
            if (byteData[SUB_W-1:0] == '0) porN = 1'b0;
            stateN = XF_IGNORE;
          end else if (byteData[DATA_W-1]) begin
            if (pendQ) begin
              stateN = XF_IGNORE;
            end else begin
              ackOut = 1'b1;
              ptrN   = byteData[SUB_W-1:0];
              stateN = XF_BUF_DATA;
            end
          end else begin
            ackOut = 1'b1;
            ptrN   = byteData[SUB_W-1:0];
            stateN = XF_DIRECT;
          end
        end
        XF_DIRECT: begin
          ackOut       = 1'b1;
          stb.shadowWr = 1'b1;
          if (ptrQ < SUB_W'(NUM_REGS - 1)) ptrN = ptrQ + 1'b1;
        end
        XF_BUF_DATA: begin
          ackOut     = 1'b1;
          stb.holdWr = 1'b1;
          stateN     = XF_BUF_DONE;
        end
        default: ;
      endcase
    end

    if (powerDip) begin
      stb      = '0;
      stb.wipe = 1'b1;
      ackOut   = 1'b0;
      stateN   = XF_IDLE;
      porN     = 1'b1;
      pendN    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= XF_IDLE;
      ptrQ   <= '0;
      porQ   <= 1'b1;
      pendQ  <= 1'b0;
    end else begin
      stateQ <= stateN;
      ptrQ   <= ptrN;
      porQ   <= porN;
      pendQ  <= pendN;
    end
  end

  // R8: a refused power-on state never acknowledges the subaddress
  assert_por_nack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (byteStb && porQ && stateQ == XF_WAIT_SUB) |-> !ackOut);

  // R6: the holding buffer is only loaded when nothing is held
  assert_single_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdWr |-> !pendQ);

  // R5: a held write only becomes pending at the end of a transfer
  assert_pend_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(startStb || stopStb));

  // R9: a dip raises the flag and leaves nothing held
  assert_dip_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerDip |=> (porQ && !pendQ));
endmodule

// File: rtl/vrbRegs.sv
module vrbRegs
  import vrb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0]          liveQ   [NUM_REGS];
  logic [DATA_W-1:0]          shadowQ [NUM_REGS];
  logic [SUB_W-1:0]           holdAddrQ;
  logic [DATA_W-1:0]          holdDataQ;
  logic [NUM_REGS*DATA_W-1:0] liveFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        liveQ[i]   <= resetVal(i);
        shadowQ[i] <= resetVal(i);
      end
      holdAddrQ <= '0;
      holdDataQ <= '0;
    end else if (stb.wipe) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        liveQ[i]   <= resetVal(i);
        shadowQ[i] <= resetVal(i);
      end
      holdAddrQ <= '0;
      holdDataQ <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (stb.shadowWr && stb.wrAddr == SUB_W'(i))
          shadowQ[i] <= stb.wrData & fieldMask(i);
        if (stb.publish)
          liveQ[i] <= shadowQ[i];
        if (stb.commit && holdAddrQ == SUB_W'(i)) begin
          liveQ[i]   <= holdDataQ & fieldMask(i);
          shadowQ[i] <= holdDataQ & fieldMask(i);
        end
      end
      if (stb.holdWr) begin
        holdAddrQ <= stb.wrAddr;
        holdDataQ <= stb.wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == IDX_W'(i)) rdData = liveQ[i];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gLive
    assign liveFlat[g*DATA_W +: DATA_W] = liveQ[g];

    // R4: bits outside a field never appear in the live copy
    assert_field_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
      (liveQ[g] & ~fieldMask(g)) == '0);
  end

  // R2: live values only move on a publish, a blanking commit or a dip
  assert_live_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.publish && !stb.commit && !stb.wipe) |=> $stable(liveFlat));
endmodule

// File: rtl/blankSyncRegBank.sv
module blankSyncRegBank
  import vrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerDip,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              addrMatch,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  output logic              ackOut,
  input  logic              vblankIn,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);
  ctrlStb_t stb;

  vrbCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .powerDip  (powerDip),
    .startStb  (startStb),
    .stopStb   (stopStb),
    .addrMatch (addrMatch),
    .byteStb   (byteStb),
    .byteData  (byteData),
    .vblankIn  (vblankIn),
    .ackOut    (ackOut),
    .stb       (stb)
  );

  vrbRegs uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: tb/tb_blankSyncRegBank.sv
`timescale 1ns/1ps
module tb_blankSyncRegBank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerDip = 1'b0;
  logic       startStb = 1'b0;
  logic       stopStb = 1'b0;
  logic       addrMatch = 1'b0;
  logic       byteStb = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       ackOut;
  logic       vblankIn = 1'b0;
  logic [3:0] rdAddr = 4'd0;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] model [12];

  // subaddress, data, expected register value after masking (R4)
  localparam logic [23:0] VEC [12] = '{
    24'h00FF0F, 24'h01A5A5, 24'h025A5A, 24'h03FF0F,
    24'h041212, 24'h053434, 24'h065656, 24'h077878,
    24'h089A9A, 24'h09BCBC, 24'h0AFF07, 24'h0BFF03
  };

  always #5 clk = ~clk;

  blankSyncRegBank dut (
    .clk(clk), .rstN(rstN), .powerDip(powerDip), .startStb(startStb),
    .stopStb(stopStb), .addrMatch(addrMatch), .byteStb(byteStb),
    .byteData(byteData), .ackOut(ackOut), .vblankIn(vblankIn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic checkReg(input string tag, input int idx, input logic [7:0] exp);
    rdAddr = 4'(idx);
    #1;
    check($sformatf("%s reg%0d", tag, idx), rdData, exp);
  endtask

  task automatic checkAll(input string tag);
    for (int i = 0; i < 12; i++) checkReg(tag, i, model[i]);
  endtask

  task automatic modelReset();
    for (int i = 0; i < 12; i++) model[i] = (i == 0) ? 8'h01 : 8'h00;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    @(negedge clk);
    byteStb = 1'b1;
    byteData = d;
    #2;
    ack = ackOut;
    @(negedge clk);
    byteStb = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startStb = 1'b1; @(negedge clk); startStb = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopStb = 1'b1; @(negedge clk); stopStb = 1'b0;
  endtask

  task automatic pulseAddr();
    @(negedge clk); addrMatch = 1'b1; @(negedge clk); addrMatch = 1'b0;
  endtask

  // full transfer of n bytes; byte i is bytes[8*i+:8], expected ack is expAck[i]
  task automatic xfer(input string tag, input logic [31:0] bytes, input int n,
                      input logic [3:0] expAck);
    logic a;
    pulseStart();
    pulseAddr();
    for (int i = 0; i < n; i++) begin
      sendByte(bytes[8*i +: 8], a);
      check($sformatf("%s ack%0d", tag, i), {7'd0, a}, {7'd0, expAck[i]});
    end
    pulseStop();
  endtask

  task automatic blankEdge();
    @(negedge clk); vblankIn = 1'b1;
    cycles(5);
  endtask

  initial begin
    logic a;
    modelReset();
    cycles(3);
    rstN = 1'b1;
    cycles(2);

    // R1: reset values
    checkAll("R1");

    // R8: power-on flag refuses transfers until the control register is addressed
    xfer("R8 refused", 32'h0000_3305, 2, 4'b0000);
    checkReg("R8 no write", 5, 8'h00);
    xfer("R8 still set", 32'h0000_3305, 2, 4'b0000);
    xfer("R8 clear", 32'h0000_0000, 1, 4'b0000);
    xfer("R8 accepted", 32'h0000_3305, 2, 4'b0011);
    model[5] = 8'h33;
    checkReg("R8 written", 5, 8'h33);

    // R2/R4: table of single direct writes
    for (int v = 0; v < 12; v++) begin
      xfer("R2 vec", {16'h0, VEC[v][15:8], VEC[v][23:16]}, 2, 4'b0011);
      model[VEC[v][19:16]] = VEC[v][7:0];
      checkReg("R4 vec", int'(VEC[v][19:16]), VEC[v][7:0]);
    end
    checkAll("R2 table");

    // R2: live value stays until the stop
    pulseStart();
    pulseAddr();
    sendByte(8'h01, a);
    check("R2 sub ack", {7'd0, a}, 8'h01);
    sendByte(8'h6B, a);
    check("R2 data ack", {7'd0, a}, 8'h01);
    cycles(3);
    checkReg("R2 before stop", 1, model[1]);
    pulseStop();
    model[1] = 8'h6B;
    checkReg("R2 after stop", 1, 8'h6B);

    // R3: auto-increment saturates at 11; out-of-range subaddress ignored
    xfer("R3 inc", 32'h3322_110A, 4, 4'b1111);
    model[10] = 8'h01;
    model[11] = 8'h03;
    checkAll("R3 inc");
    xfer("R3 range", 32'h0000_7720, 2, 4'b0011);
    checkAll("R3 range");

    // R5/R6: buffered write held until a blanking edge
    xfer("R6 extra", 32'h0099_3C82, 3, 4'b0011);
    cycles(10);
    checkReg("R5 held", 2, model[2]);
    xfer("R6 second", 32'h0000_4481, 2, 4'b0000);
    // R7: direct write while a buffered one is held
    xfer("R7 direct", 32'h0000_5501, 2, 4'b0011);
    model[1] = 8'h55;
    checkReg("R7 applied", 1, 8'h55);
    blankEdge();
    model[2] = 8'h3C;
    checkReg("R5 commit", 2, 8'h3C);
    checkReg("R6 not replaced", 1, 8'h55);
    checkAll("R5 after commit");

    // R5: blanking held high applies nothing new
    xfer("R5 level", 32'h0000_1082, 2, 4'b0011);
    cycles(8);
    checkReg("R5 level held", 2, 8'h3C);
    @(negedge clk); vblankIn = 1'b0;
    cycles(4);
    blankEdge();
    model[2] = 8'h10;
    checkReg("R5 second edge", 2, 8'h10);
    @(negedge clk); vblankIn = 1'b0;
    cycles(3);

    // R9: supply dip wipes registers and the held write
    xfer("R9 hold", 32'h0000_0F83, 2, 4'b0011);
    @(negedge clk); powerDip = 1'b1; @(negedge clk); powerDip = 1'b0;
    modelReset();
    checkAll("R9 wiped");
    blankEdge();
    checkReg("R9 dropped", 3, 8'h00);
    @(negedge clk); vblankIn = 1'b0;
    cycles(3);
    xfer("R9 flag", 32'h0000_0503, 2, 4'b0000);
    xfer("R9 clear", 32'h0000_0000, 1, 4'b0000);
    xfer("R9 buffer free", 32'h0000_2184, 2, 4'b0011);
    blankEdge();
    model[4] = 8'h21;
    checkAll("R9 after");
    @(negedge clk); vblankIn = 1'b0;

    // R10: out-of-range read index
    checkReg("R10", 12, 8'h00);
    checkReg("R10", 15, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule